// File: doc/BRIEF.md
# Per-Processor Mode Time Accounting Unit

This unit keeps the time bookkeeping of one processor as it moves out of task execution, idling or a halted state and into the privileged kernel. It owns a down-counting task timer and two running totals: one for time spent contending for kernel access, one for time spent idle. An external interrupt sequencer drives one-cycle strobes at the phase boundaries. The unit answers each strobe by capturing the timer, turning the capture into a remaining-slice value or an elapsed time, and reloading the timer to its maximum.

At kernel entry a small state machine folds the latched elapsed times into the totals. The interrupting total is always updated. The idle total is updated only when the most recent state save came from the idle mode. A status line, `meas_ok`, drops for exactly the cycles in which a total is being written, so that an observer never reads a total while it changes.

States: `ST_RUN` (waiting for strobes), `ST_ADD_INTR` (the interrupting total is written at the end of this cycle) and `ST_ADD_IDLE` (the idle total is written at the end of this cycle). Transitions: `ST_RUN` to `ST_ADD_INTR` on the kernel-entry strobe. `ST_ADD_INTR` to `ST_ADD_IDLE` when the source was idle, otherwise back to `ST_RUN`. `ST_ADD_IDLE` to `ST_RUN` always.

Top module: `mode_time_acct`

## Requirements
- R1: After reset the timer holds its maximum (all ones, 2^TW-1), every captured value and both totals are zero, `meas_ok` is 1 and the state is `ST_RUN`.
- R2: Each clock with `tick_en` high and no reload strobe lowers the timer by one. At zero the timer stays at zero.
- R3: A cycle with `save_exec` high makes `slice_rem` equal to the timer value of that cycle from the next cycle on, and the timer is reloaded to its maximum.
- R4: A cycle with `save_idle` high makes `idle_elapsed` equal to maximum minus the timer value of that cycle from the next cycle on, and the timer is reloaded to its maximum.
- R5: A cycle with `intr_end` high makes `intr_elapsed` equal to maximum minus the timer value of that cycle from the next cycle on, and the timer is reloaded to its maximum.
- R6: A `kern_entry` strobe in `ST_RUN` moves the machine to `ST_ADD_INTR`. At the end of that cycle `intr_latched` is added to `intr_total`, so the new total is visible two cycles after the strobe cycle.
- R7: `idle_total` gains `idle_elapsed` one cycle after the interrupting update only if the last save strobe before `kern_entry` was `save_idle`. After `save_exec`, or after no save at all (the halted source), it stays unchanged. The source mark is cleared when the fold completes.
- R8: `meas_ok` is 0 in exactly the cycles in which a total is written (`ST_ADD_INTR`, `ST_ADD_IDLE`) and 1 otherwise. Neither total changes while `meas_ok` was 1 in the preceding cycle.
- R9: Both totals wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer decrement enable |
| save_exec | input | 1 | State save leaving task execution |
| save_idle | input | 1 | State save leaving idle mode |
| intr_end | input | 1 | End of the interrupting phase |
| kern_entry | input | 1 | Kernel-entry update strobe |
| slice_rem | output | TW | Captured remaining time slice |
| idle_elapsed | output | TW | Latched idle elapsed time |
| intr_latched | output | TW | Latched interrupting elapsed time |
| intr_total | output | AW | Interrupting time total |
| idle_total | output | AW | Idle time total |
| meas_ok | output | 1 | Low while a total is being written |

## Verification
The bench builds the unit with TW=8 and AW=10. An 8-bit timer lets runs of 255 ticks and more reach saturation at zero within a few hundred cycles. A 10-bit total wraps after only a handful of full-scale idle and interrupting folds, so the wrap of R9 is reached within a short vector table. The table mixes execution, idle and halted sources in an order that shows the idle mark being cleared between kernel entries.

// File: rtl/mta_pkg.sv
package mta_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_ADD_INTR = 2'd1,
        ST_ADD_IDLE = 2'd2
    } mta_state_e;

    localparam int NUM_TOTALS = 2;
    localparam int IDX_INTR   = 0;
    localparam int IDX_IDLE   = 1;

endpackage

// File: rtl/mta_timer.sv
module mta_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          reload,
    output logic [TW-1:0] count
);
    localparam logic [TW-1:0] MAXV = {TW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= MAXV;
        end else if (reload) begin
            count <= MAXV;
        end else if (tick_en && (count != '0)) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/mta_accum.sv
module mta_accum #(
    parameter int TW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [TW-1:0] addend,
    output logic [AW-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + AW'(addend);
        end
    end
endmodule

// File: rtl/mode_time_acct.sv
module mode_time_acct
    import mta_pkg::*;
#(
    parameter int TW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          save_exec,
    input  logic          save_idle,
    input  logic          intr_end,
    input  logic          kern_entry,
    output logic [TW-1:0] slice_rem,
    output logic [TW-1:0] idle_elapsed,
    output logic [TW-1:0] intr_latched,
    output logic [AW-1:0] intr_total,
    output logic [AW-1:0] idle_total,
    output logic          meas_ok
);
    localparam logic [TW-1:0] MAXV = {TW{1'b1}};

    mta_state_e    state_q, state_d;
    logic [TW-1:0] timer_q;
    logic          reload;
    logic          src_idle_q;
    logic [NUM_TOTALS-1:0]         add_en;
    logic [NUM_TOTALS-1:0][TW-1:0] addend;
    logic [NUM_TOTALS-1:0][AW-1:0] totals;

    assign reload = save_exec | save_idle | intr_end;

    mta_timer #(.TW(TW)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .reload  (reload),
        .count   (timer_q)
    );

    // Captures taken at phase boundaries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slice_rem    <= '0;
            idle_elapsed <= '0;
            intr_latched <= '0;
        end else begin
            if (save_exec) slice_rem    <= timer_q;
            if (save_idle) idle_elapsed <= MAXV - timer_q;
            if (intr_end)  intr_latched <= MAXV - timer_q;
        end
    end

    // Source mark: set by an idle save, cleared by an execution save or a finished fold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_idle_q <= 1'b0;
        end else if (save_idle) begin
            src_idle_q <= 1'b1;
        end else if (save_exec || (state_q != ST_RUN && state_d == ST_RUN)) begin
            src_idle_q <= 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (kern_entry) state_d = ST_ADD_INTR;
            ST_ADD_INTR: state_d = src_idle_q ? ST_ADD_IDLE : ST_RUN;
            ST_ADD_IDLE: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        add_en  = '0;
        meas_ok = 1'b1;
        unique case (state_q)
            ST_RUN: ;
            ST_ADD_INTR: begin
                add_en[IDX_INTR] = 1'b1;
                meas_ok          = 1'b0;
            end
            ST_ADD_IDLE: begin
                add_en[IDX_IDLE] = 1'b1;
                meas_ok          = 1'b0;
            end
            default: ;
        endcase
    end

    assign addend[IDX_INTR] = intr_latched;
    assign addend[IDX_IDLE] = idle_elapsed;

    for (genvar g = 0; g < NUM_TOTALS; g++) begin : g_total
        mta_accum #(.TW(TW), .AW(AW)) acc_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .add_en (add_en[g]),
            .addend (addend[g]),
            .sum    (totals[g])
        );
    end

    assign intr_total = totals[IDX_INTR];
    assign idle_total = totals[IDX_IDLE];
endmodule

// File: rtl/mta_chk.sv
module mta_chk
    import mta_pkg::*;
#(
    parameter int TW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          save_exec,
    input logic          save_idle,
    input logic          intr_end,
    input logic          kern_entry,
    input logic [TW-1:0] timer_q,
    input logic [TW-1:0] slice_rem,
    input logic [TW-1:0] intr_latched,
    input logic [TW-1:0] idle_elapsed,
    input logic [AW-1:0] intr_total,
    input logic [AW-1:0] idle_total,
    input logic          meas_ok,
    input mta_state_e    state_q
);
    localparam logic [TW-1:0] MAXV = {TW{1'b1}};
    logic any_reload;
    assign any_reload = save_exec | save_idle | intr_end;

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !any_reload && timer_q != '0) |=> (timer_q == $past(timer_q) - 1'b1));

    a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_q == '0 && !any_reload) |=> (timer_q == '0));

    a_r3_slice_capture: assert property (@(posedge clk) disable iff (!rst_n)
        save_exec |=> (slice_rem == $past(timer_q)) && (timer_q == MAXV));

    a_r4_idle_capture: assert property (@(posedge clk) disable iff (!rst_n)
        save_idle |=> (idle_elapsed == MAXV - $past(timer_q)));

    a_r5_intr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        intr_end |=> (intr_latched == MAXV - $past(timer_q)));

    a_r6_enter_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (kern_entry && state_q == ST_RUN) |=> !meas_ok);

    a_r8_totals_steady: assert property (@(posedge clk) disable iff (!rst_n)
        meas_ok |=> ($stable(intr_total) && $stable(idle_total)));

    a_r7_idle_steady_in_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADD_INTR) |=> $stable(idle_total));
endmodule

bind mode_time_acct mta_chk #(.TW(TW), .AW(AW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .save_exec    (save_exec),
    .save_idle    (save_idle),
    .intr_end     (intr_end),
    .kern_entry   (kern_entry),
    .timer_q      (timer_q),
    .slice_rem    (slice_rem),
    .intr_latched (intr_latched),
    .idle_elapsed (idle_elapsed),
    .intr_total   (intr_total),
    .idle_total   (idle_total),
    .meas_ok      (meas_ok),
    .state_q      (state_q)
);

// File: tb/mode_time_acct_tb.sv
module mode_time_acct_tb_top;
    localparam int TW = 8;
    localparam int AW = 10;
    localparam int CLK_PERIOD = 10;
    localparam int MAXT = (1 << TW) - 1;
    localparam int MODW = 1 << AW;
    localparam int NVEC = 10;
    // columns: source (0 execution, 1 idle, 2 halted), ticks before save, ticks in interrupting phase
    localparam int VEC [NVEC][3] = '{
        '{0, 10, 3}, '{1, 40, 7}, '{2, 5, 6}, '{0, 300, 0}, '{1, 255, 255},
        '{2, 0, 1}, '{1, 0, 0}, '{1, 260, 270}, '{0, 0, 255}, '{1, 255, 255}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, save_exec = 1'b0, save_idle = 1'b0, intr_end = 1'b0, kern_entry = 1'b0;
    logic [TW-1:0] slice_rem, idle_elapsed, intr_latched;
    logic [AW-1:0] intr_total, idle_total;
    logic meas_ok;

    int checks = 0;
    int errors = 0;
    int exp_t, exp_intr_tot, exp_idle_tot, exp_idle_el;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_time_acct #(.TW(TW), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .save_exec(save_exec),
        .save_idle(save_idle), .intr_end(intr_end), .kern_entry(kern_entry),
        .slice_rem(slice_rem), .idle_elapsed(idle_elapsed), .intr_latched(intr_latched),
        .intr_total(intr_total), .idle_total(idle_total), .meas_ok(meas_ok)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        exp_t = (exp_t - n < 0) ? 0 : exp_t - n;
    endtask

    task automatic run_vec(input int src, input int n1, input int n2);
        int il;
        ticks(n1);
        if (src == 0) begin
            save_exec = 1'b1; @(negedge clk); save_exec = 1'b0;
            chk("R3 slice_rem (R2 count)", int'(slice_rem), exp_t);
            exp_t = MAXT;
        end else if (src == 1) begin
            save_idle = 1'b1; @(negedge clk); save_idle = 1'b0;
            exp_idle_el = MAXT - exp_t;
            chk("R4 idle_elapsed", int'(idle_elapsed), exp_idle_el);
            exp_t = MAXT;
        end
        ticks(n2);
        intr_end = 1'b1; @(negedge clk); intr_end = 1'b0;
        il = MAXT - exp_t;
        chk("R5 intr_latched", int'(intr_latched), il);
        exp_t = MAXT;
        kern_entry = 1'b1; @(negedge clk); kern_entry = 1'b0;
        chk("R8 meas_ok low in intr update", int'(meas_ok), 0);
        chk("R6 intr_total before write", int'(intr_total), exp_intr_tot);
        @(negedge clk);
        exp_intr_tot = (exp_intr_tot + il) % MODW;
        chk("R6 R9 intr_total after write", int'(intr_total), exp_intr_tot);
        if (src == 1) begin
            chk("R8 meas_ok low in idle update", int'(meas_ok), 0);
            @(negedge clk);
            exp_idle_tot = (exp_idle_tot + exp_idle_el) % MODW;
            chk("R7 R9 idle_total after write", int'(idle_total), exp_idle_tot);
        end else begin
            chk("R7 idle_total unchanged", int'(idle_total), exp_idle_tot);
        end
        chk("R8 meas_ok high after fold", int'(meas_ok), 1);
    endtask

    initial begin
        exp_t = MAXT; exp_intr_tot = 0; exp_idle_tot = 0; exp_idle_el = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 slice_rem", int'(slice_rem), 0);
        chk("R1 idle_elapsed", int'(idle_elapsed), 0);
        chk("R1 intr_latched", int'(intr_latched), 0);
        chk("R1 intr_total", int'(intr_total), 0);
        chk("R1 idle_total", int'(idle_total), 0);
        chk("R1 meas_ok", int'(meas_ok), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: timer at maximum, seen as zero elapsed time
        intr_end = 1'b1; @(negedge clk); intr_end = 1'b0;
        chk("R1 timer at max", int'(intr_latched), 0);
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2]);
        // R2: a reload strobe wins over a tick in the same cycle
        ticks(4);
        tick_en = 1'b1; save_exec = 1'b1; @(negedge clk); save_exec = 1'b0;
        chk("R2 R3 capture with tick", int'(slice_rem), MAXT - 4);
        @(negedge clk); tick_en = 1'b0;
        save_exec = 1'b1; @(negedge clk); save_exec = 1'b0;
        chk("R2 reload then one tick", int'(slice_rem), MAXT - 1);
        // R8: kern_entry during a fold is ignored
        kern_entry = 1'b1; @(negedge clk);
        chk("R8 fold started", int'(meas_ok), 0);
        @(negedge clk); kern_entry = 1'b0;
        chk("R8 second strobe in fold ignored", int'(meas_ok), 1);
        exp_intr_tot = (exp_intr_tot + int'(intr_latched)) % MODW;
        chk("R6 total after repeated fold", int'(intr_total), exp_intr_tot);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule